// File: doc/BRIEF.md
# Prescaled Reload Timeout Timer

This block is a down-counting watchdog for a contactless reader's link layer. A programmable prescaler slows the system clock to a timer tick. A 16-bit reload value sets how many ticks may pass before the timer gives up. When the count runs out, the block raises a timer interrupt flag. The flag stays set until software writes a one to it.

Software sets the timer up through an eight-entry byte register interface. The prescaler is twelve bits wide. Its low byte has its own register, and its top four bits share a mode register with an auto-start enable. The reload value takes two byte registers. Software can start or stop the count through a command register. With auto-start enabled, a one-cycle end-of-transmission pulse from the transmitter starts the count instead. A start that arrives while the timer is already counting reloads it and begins the timeout again from the full reload value.

Top module: `presc_timeout_timer`

## Requirements
- R1: After reset every register reads 0x00, the timer is stopped and `irq_o` is low.
- R2: Address 0 (mode) holds the auto-start enable in bit 7 and prescaler bits 11:8 in bits 3:0, and bits 6:4 read 0. Address 1 holds prescaler bits 7:0. Addresses 2 and 3 hold reload bits 15:8 and 7:0. All four registers read back what was written.
- R3: With prescaler value P, a tick occurs every 2·P+1 clocks. The running count drops by one per tick and is readable at address 4 (bits 15:8) and address 5 (bits 7:0).
- R4: A start loads the counter with the reload value R in the next cycle. Expiry comes R·(2·P+1) clocks after the start edge, and R=0 behaves as R=1. The counter then rests at zero and stops.
- R5: Expiry sets the timer interrupt flag. The flag is bit 0 of address 6 and is also driven on `irq_o`.
- R6: A write to address 6 with bit 0 set clears the flag. A write with bit 0 clear leaves it set.
- R7: When expiry and a clearing write fall in the same cycle, the flag ends up set.
- R8: `tx_end_i` starts the timer only when the auto-start enable (mode bit 7) is 1. When it is 0, the pulse changes neither the count nor the flag.
- R9: A start while the timer is counting reloads the counter and restarts the prescaler phase, so expiry moves to R·(2·P+1) clocks after the new start.
- R10: A write to address 7 with bit 0 set starts the timer, and bit 1 set stops it with the count frozen. When both bits are set, the start wins.
- R11: A start in the same cycle as the final tick wins: the flag is not set and the count reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the timer reference |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on the address |
| tx_end_i | input | 1 | One-cycle end-of-transmission pulse |
| irq_o | output | 1 | Timer interrupt flag |

## Verification
Two pairs of functions can collide in a single cycle. The first pair is expiry and a software clear of the flag. The bench provokes it with reload 1 and prescaler 2, timing a clearing write to land on the fifth edge after the start, which is the expiry edge. The flag must read set afterwards. The second pair is expiry and a fresh start. The bench issues a start command on that same edge and expects the flag to stay low and the count to read 1. The flag must then rise one full timeout later.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

    typedef enum logic [2:0] {
        A_MODE   = 3'd0,
        A_PRE_LO = 3'd1,
        A_RLD_HI = 3'd2,
        A_RLD_LO = 3'd3,
        A_CNT_HI = 3'd4,
        A_CNT_LO = 3'd5,
        A_IRQ    = 3'd6,
        A_CMD    = 3'd7
    } reg_addr_e;

    localparam int unsigned AUTO_BIT  = 7;
    localparam int unsigned FLAG_BIT  = 0;
    localparam int unsigned START_BIT = 0;
    localparam int unsigned STOP_BIT  = 1;

endpackage

// File: rtl/ptt_prescaler.sv
module ptt_prescaler #(
    parameter int unsigned LIM_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [LIM_W-1:0] phase;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        tick_o = run_i && (s_q.phase >= limit_i);
        if (restart_i || !run_i || tick_o) begin
            s_d.phase = '0;
        end else begin
            s_d.phase = s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ptt_downcount.sv
module ptt_downcount #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             run_o,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        expire_o = 1'b0;
        if (start_i) begin
            s_d.cnt = reload_i;
            s_d.run = 1'b1;
        end else if (stop_i) begin
            s_d.run = 1'b0;
        end else if (s_q.run && tick_i) begin
            if (s_q.cnt <= CNT_W'(1)) begin
                s_d.cnt  = '0;
                s_d.run  = 1'b0;
                expire_o = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o = s_q.cnt;
    assign run_o   = s_q.run;

endmodule

// File: rtl/presc_timeout_timer.sv
module presc_timeout_timer
    import ptt_pkg::*;
#(
    parameter int unsigned PRESC_W  = 12,
    parameter int unsigned RELOAD_W = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       reg_we_i,
    input  logic [2:0] reg_addr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic       tx_end_i,
    output logic       irq_o
);

    localparam int unsigned LIM_W = PRESC_W + 1;

    typedef struct packed {
        logic                auto_en;
        logic [PRESC_W-1:0]  presc;
        logic [RELOAD_W-1:0] reload;
        logic                irq;
    } cfg_t;

    cfg_t r_d, r_q;

    reg_addr_e           addr;
    logic [11:0]         pre12;
    logic [15:0]         rld16;
    logic [15:0]         cnt16;
    logic                cmd_wr;
    logic                start;
    logic                stop;
    logic                tick;
    logic                expire;
    logic                run;
    logic                auto_en;
    logic [RELOAD_W-1:0] count;
    logic [RELOAD_W-1:0] reload;
    logic [LIM_W-1:0]    limit;

    always_comb begin
        addr   = reg_addr_e'(reg_addr_i);
        pre12  = 12'(r_q.presc);
        rld16  = 16'(r_q.reload);
        cnt16  = 16'(count);
        r_d    = r_q;

        if (reg_we_i) begin
            case (addr)
                A_MODE: begin
                    r_d.auto_en = reg_wdata_i[AUTO_BIT];
                    r_d.presc   = PRESC_W'({reg_wdata_i[3:0], pre12[7:0]});
                end
                A_PRE_LO: r_d.presc  = PRESC_W'({pre12[11:8], reg_wdata_i});
                A_RLD_HI: r_d.reload = RELOAD_W'({reg_wdata_i, rld16[7:0]});
                A_RLD_LO: r_d.reload = RELOAD_W'({rld16[15:8], reg_wdata_i});
                A_IRQ: begin
                    if (reg_wdata_i[FLAG_BIT]) begin
                        r_d.irq = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (expire) begin
            r_d.irq = 1'b1;
        end

        cmd_wr = reg_we_i && (addr == A_CMD);
        start  = (cmd_wr && reg_wdata_i[START_BIT]) || (tx_end_i && r_q.auto_en);
        stop   = cmd_wr && reg_wdata_i[STOP_BIT];

        case (addr)
            A_MODE:   reg_rdata_o = {r_q.auto_en, 3'b000, pre12[11:8]};
            A_PRE_LO: reg_rdata_o = pre12[7:0];
            A_RLD_HI: reg_rdata_o = rld16[15:8];
            A_RLD_LO: reg_rdata_o = rld16[7:0];
            A_CNT_HI: reg_rdata_o = cnt16[15:8];
            A_CNT_LO: reg_rdata_o = cnt16[7:0];
            A_IRQ:    reg_rdata_o = {7'b0, r_q.irq};
            default:  reg_rdata_o = 8'h00;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign limit   = {r_q.presc, 1'b0};
    assign auto_en = r_q.auto_en;
    assign reload  = r_q.reload;
    assign irq_o   = r_q.irq;

    ptt_prescaler #(
        .LIM_W(LIM_W)
    ) u_presc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(start),
        .run_i    (run),
        .limit_i  (limit),
        .tick_o   (tick)
    );

    ptt_downcount #(
        .CNT_W(RELOAD_W)
    ) u_count (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .stop_i  (stop),
        .tick_i  (tick),
        .reload_i(reload),
        .count_o (count),
        .run_o   (run),
        .expire_o(expire)
    );

endmodule

// File: rtl/ptt_chk.sv
module ptt_chk #(
    parameter int unsigned RELOAD_W = 16
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                reg_we_i,
    input logic [2:0]          reg_addr_i,
    input logic                wbit0_i,
    input logic                tx_end_i,
    input logic                irq_o,
    input logic                auto_i,
    input logic                start_i,
    input logic                stop_i,
    input logic                tick_i,
    input logic                expire_i,
    input logic                run_i,
    input logic [RELOAD_W-1:0] count_i,
    input logic [RELOAD_W-1:0] reload_i
);

    p_hold_between_ticks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i && !tick_i && !start_i && !stop_i |=> $stable(count_i));

    p_load_on_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (count_i == $past(reload_i)) && run_i);

    p_rest_after_expiry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |=> !run_i && (count_i == '0));

    p_flag_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(expire_i));

    p_clear_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_we_i && (reg_addr_i == 3'd6) && wbit0_i && !expire_i |=> !irq_o);

    p_set_beats_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |=> irq_o);

    p_tx_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_end_i && !auto_i && !(reg_we_i && (reg_addr_i == 3'd7)) && !run_i |=> !run_i);

    p_stop_freezes_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i && !start_i |=> !run_i);

    p_start_beats_expiry_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !irq_o |=> !irq_o);

endmodule

bind presc_timeout_timer ptt_chk #(
    .RELOAD_W(RELOAD_W)
) u_ptt_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reg_we_i  (reg_we_i),
    .reg_addr_i(reg_addr_i),
    .wbit0_i   (reg_wdata_i[0]),
    .tx_end_i  (tx_end_i),
    .irq_o     (irq_o),
    .auto_i    (auto_en),
    .start_i   (start),
    .stop_i    (stop),
    .tick_i    (tick),
    .expire_i  (expire),
    .run_i     (run),
    .count_i   (count),
    .reload_i  (reload)
);

// File: tb/presc_timeout_timer_tb_top.sv
module presc_timeout_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tx_end = 1'b0;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    presc_timeout_timer dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .reg_we_i   (reg_we),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .tx_end_i   (tx_end),
        .irq_o      (irq)
    );

    task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                        input logic tx, input int kind, input logic [7:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        reg_we    = we;
        reg_addr  = a;
        reg_wdata = d;
        tx_end    = tx;
        if (kind >= 0) begin
            it.kind = kind;
            it.exp  = exp;
            it.tag  = tag;
            sb_q.push_back(it);
        end
    endtask

    task automatic idle();
        step(1'b0, 3'd0, 8'h00, 1'b0, -1, 8'h00, "");
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, -1, 8'h00, "");
    endtask

    task automatic txp();
        step(1'b0, 3'd0, 8'h00, 1'b1, -1, 8'h00, "");
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        step(1'b0, a, 8'h00, 1'b0, 0, exp, tag);
    endtask

    task automatic ichk(input logic exp, input string tag);
        step(1'b0, 3'd0, 8'h00, 1'b0, 1, {7'b0, exp}, tag);
    endtask

    // monitor: samples a quarter period before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = (it.kind == 1) ? {7'b0, irq} : reg_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual=0x%02h expected=0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 reset register");
        ichk(1'b0, "R1 reset irq");

        // R2 register readback
        wr(3'd0, 8'hFF); rd(3'd0, 8'h8F, "R2 mode");
        wr(3'd0, 8'h00); rd(3'd0, 8'h00, "R2 mode clear");
        wr(3'd1, 8'hA5); rd(3'd1, 8'hA5, "R2 prescaler low");
        wr(3'd2, 8'h12); rd(3'd2, 8'h12, "R2 reload high");
        wr(3'd3, 8'h34); rd(3'd3, 8'h34, "R2 reload low");

        // R3 R4 R5: P=2, R=3 -> expiry 15 clocks after start
        wr(3'd1, 8'h02); wr(3'd2, 8'h00); wr(3'd3, 8'h03);
        wr(3'd7, 8'h01);
        rd(3'd5, 8'h03, "R4 load");
        repeat (3) idle();
        rd(3'd5, 8'h03, "R3 before tick");
        rd(3'd5, 8'h02, "R3 after tick");
        repeat (8) idle();
        ichk(1'b0, "R4 not yet expired");
        ichk(1'b1, "R5 irq pin");
        rd(3'd6, 8'h01, "R5 flag bit");
        rd(3'd5, 8'h00, "R4 rests at zero");
        rd(3'd4, 8'h00, "R4 high byte zero");

        // R6 clearing
        wr(3'd6, 8'h00); rd(3'd6, 8'h01, "R6 zero write keeps flag");
        wr(3'd6, 8'h01); ichk(1'b0, "R6 clear pin");
        rd(3'd6, 8'h00, "R6 clear bit");

        // R3 with P=0: one tick per clock
        wr(3'd1, 8'h00);
        wr(3'd7, 8'h01);
        idle(); idle();
        ichk(1'b0, "R3 P0 early");
        ichk(1'b1, "R3 P0 expiry");
        wr(3'd6, 8'h01);

        // R4 zero reload behaves as one
        wr(3'd1, 8'h02); wr(3'd3, 8'h00);
        wr(3'd7, 8'h01);
        repeat (4) idle();
        ichk(1'b0, "R4 zero reload early");
        ichk(1'b1, "R4 zero reload expiry");
        wr(3'd6, 8'h01);

        // R8 auto-start gating
        wr(3'd3, 8'h05);
        txp();
        repeat (30) idle();
        ichk(1'b0, "R8 pulse ignored irq");
        rd(3'd5, 8'h00, "R8 pulse ignored count");
        wr(3'd0, 8'h80);
        txp();
        rd(3'd5, 8'h05, "R8 auto load");
        repeat (23) idle();
        ichk(1'b0, "R8 auto early");
        ichk(1'b1, "R8 auto expiry");
        wr(3'd6, 8'h01); wr(3'd0, 8'h00);

        // R9 restart while counting
        wr(3'd7, 8'h01);
        repeat (10) idle();
        rd(3'd5, 8'h03, "R9 mid count");
        wr(3'd7, 8'h01);
        repeat (24) idle();
        ichk(1'b0, "R9 old deadline moved");
        ichk(1'b1, "R9 new deadline");
        wr(3'd6, 8'h01);

        // R10 stop and start-wins
        wr(3'd7, 8'h01);
        repeat (5) idle();
        rd(3'd5, 8'h04, "R10 before stop");
        wr(3'd7, 8'h02);
        repeat (20) idle();
        rd(3'd5, 8'h04, "R10 frozen count");
        ichk(1'b0, "R10 no expiry when stopped");
        wr(3'd7, 8'h03);
        rd(3'd5, 8'h05, "R10 start wins over stop");
        wr(3'd7, 8'h02);

        // R7 expiry and clear in the same cycle
        wr(3'd3, 8'h01);
        wr(3'd7, 8'h01);
        repeat (4) idle();
        wr(3'd6, 8'h01);
        ichk(1'b1, "R7 set wins");
        wr(3'd6, 8'h01);
        ichk(1'b0, "R7 later clear");

        // R11 start on the expiry edge
        wr(3'd7, 8'h01);
        repeat (4) idle();
        wr(3'd7, 8'h01);
        ichk(1'b0, "R11 no flag");
        rd(3'd5, 8'h01, "R11 reloaded");
        idle(); idle();
        ichk(1'b0, "R11 before new expiry");
        ichk(1'b1, "R11 new expiry");

        repeat (3) idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule